// File: doc/BRIEF.md
# Edge/Level Interrupt Request Capture

This block turns a set of raw interrupt request lines into a vector of pending-request bits. Each line is given its own trigger mode by a small configuration register. A line in level mode has a pending bit that follows the input. A line in edge mode latches a pending bit on a rising edge and holds it until the line is acknowledged. The block is meant to sit in front of a priority resolver. The resolver reads the pending vector and, once it has granted a line, reports that line's index back on the acknowledge port.

The trigger-mode register is written and read as one word. A fixed, parameterised write mask ties some of its bits to edge mode permanently, because those lines are wired to sources that must never be treated as levels. A synchronous clear input flushes the pending bits and the stored previous levels without disturbing the configuration. The active-low reset returns every register, including the configuration, to zero. Request inputs are assumed to be synchronous to the block clock.

Top module: `irq_trig_capture`

## Requirements
- R1: For a line whose trigger-mode bit is 1 (level mode), the pending bit at the clock edge equals the request input sampled at that edge, so it is set while the input is high and cleared once it is low.
- R2: For a line whose trigger-mode bit is 0 (edge mode), the pending bit is set at a clock edge where the input is 1 and the stored previous sample of that line is 0. An input held high does not set the bit again after it was acknowledged.
- R3: In edge mode a falling input updates the stored previous sample but leaves an already set pending bit unchanged.
- R4: A write to the trigger-mode register stores the write data ANDed with the parameter MODE_WMASK (default 0xF8). Bits outside the mask always read back as 0.
- R5: An acknowledge naming line n (ack_line is the binary index n, with bit n of the vectors belonging to line n) clears pending bit n when line n is in edge mode. Every other pending bit is unaffected.
- R6: An acknowledge naming a level-mode line has no effect on its pending bit while that line's input stays high.
- R7: When an acknowledge and a rising edge on the same edge-mode line arrive in the same cycle, the pending bit is set after that edge.
- R8: The clear input empties the pending bits and the stored previous samples at the next edge and keeps the trigger-mode register. An edge-mode line that is still high when clear is released is therefore seen as a new rising edge one cycle later.
- R9: While rst_n is low, a clock edge sets the pending bits, the stored previous samples and the trigger-mode register to 0.
- R10: A trigger-mode write becomes visible on mode_rdata after the edge that captures it. The new mode governs capture from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of all state |
| clr | input | 1 | Synchronous clear of the pending bits and previous samples |
| req_in | input | NUM_LINES | Raw request lines, synchronous to clk |
| mode_we | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata | input | NUM_LINES | Trigger-mode write data; 1 = level, 0 = edge |
| mode_rdata | output | NUM_LINES | Current trigger-mode register contents |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | IDX_W | Binary index of the acknowledged line |
| pending | output | NUM_LINES | Pending-request vector |

## Verification
Every result is due exactly one clock edge after its stimulus. Pending bits and the mode readback are registered once, and a mode write needs one more edge before it changes how lines are captured. The bench drives inputs on the falling edge and steps a reference model by one edge for each drive. It compares the outputs on the next falling edge, when the registers have settled, so it neither reads a value early nor skips one. The directed cases for clear release and mode changes check the pending vector on each of the two edges that follow, so a one-cycle slip shows up.

// File: rtl/irqcap_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the interrupt request capture block.
// Assumes nothing beyond being compiled before the modules that import it.
package irqcap_pkg;

    // Trigger mode encoding for one request line.
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    // Next pending value for one line, shared by the line cell.
    function automatic logic next_pend(
        input trig_mode_e mode,
        input logic       req,
        input logic       prev,
        input logic       pend,
        input logic       ack_hit
    );
        logic rise;
        rise = req & ~prev;
        if (mode == TRIG_LEVEL)
            return req;
        else
            return rise | (pend & ~ack_hit);
    endfunction

endpackage

// File: rtl/irqcap_mode_reg.sv
`timescale 1ns/1ps
// Module: trigger-mode configuration register with a hard-wired write mask.
// Bits cleared in WMASK are forced to edge mode and read back as 0.
// Assumes a synchronous active-low reset; the capture clear does not reach here.
module irqcap_mode_reg #(
    parameter int                   NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WMASK     = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] q
);

    logic [NUM_LINES-1:0] mode_q;

    // Hold the masked mode word; only reset or a write change it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (we)
            mode_q <= wdata & WMASK;
    end

    assign q = mode_q;

endmodule

// File: rtl/irqcap_ack_dec.sv
`timescale 1ns/1ps
// Module: turns a binary acknowledge index into a one-hot clear vector.
// Assumes ack_line addresses a line below NUM_LINES; larger indices hit nothing.
module irqcap_ack_dec #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    output logic [NUM_LINES-1:0] ack_hit
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        // One comparator per line selects the acknowledged line.
        always_comb begin
            ack_hit[g] = ack_valid && (ack_line == IDX_W'(g));
        end
    end

endmodule

// File: rtl/irqcap_line.sv
`timescale 1ns/1ps
// Module: capture cell for one request line.
// Keeps the previous input sample and the pending bit. In level mode the
// pending bit follows the input; in edge mode a rising edge sets it and only
// an acknowledge clears it, a new edge winning over a same-cycle acknowledge.
// Assumes req is synchronous to clk.
module irqcap_line
    import irqcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       req,
    input  trig_mode_e mode,
    input  logic       ack_hit,
    output logic       pend
);

    logic prev_q;
    logic pend_q;
    logic pend_d;

    // Next pending value from the mode, the edge detector and the acknowledge.
    always_comb begin
        pend_d = next_pend(mode, req, prev_q, pend_q, ack_hit);
    end

    // Store the previous sample and the pending bit; clear empties both.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_trig_capture.sv
`timescale 1ns/1ps
// Module: top of the edge/level interrupt request capture block.
// Combines the masked trigger-mode register, the acknowledge decoder and one
// capture cell per request line. Produces only the pending vector; priority
// and masking belong to the consumer. Assumes synchronous request inputs.
module irq_trig_capture
    import irqcap_pkg::*;
#(
    parameter int                   NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hF8,
    localparam int                  IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_LINES-1:0] req_in,
    input  logic                 mode_we,
    input  logic [NUM_LINES-1:0] mode_wdata,
    output logic [NUM_LINES-1:0] mode_rdata,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] mode_vec;
    logic [NUM_LINES-1:0] ack_vec;

    irqcap_mode_reg #(
        .NUM_LINES (NUM_LINES),
        .WMASK     (MODE_WMASK)
    ) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wdata (mode_wdata),
        .q     (mode_vec)
    );

    irqcap_ack_dec #(
        .NUM_LINES (NUM_LINES)
    ) u_ack (
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .ack_hit   (ack_vec)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irqcap_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .req     (req_in[g]),
            .mode    (trig_mode_e'(mode_vec[g])),
            .ack_hit (ack_vec[g]),
            .pend    (pending[g])
        );
    end

    assign mode_rdata = mode_vec;

endmodule

// File: rtl/irqcap_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for irq_trig_capture, attached by bind.
// Keeps its own copy of the previous request sample to judge rising edges.
module irqcap_chk #(
    parameter int                   NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hF8,
    localparam int                  IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic [NUM_LINES-1:0] req_in,
    input logic                 mode_we,
    input logic [NUM_LINES-1:0] mode_wdata,
    input logic [NUM_LINES-1:0] mode_rdata,
    input logic                 ack_valid,
    input logic [IDX_W-1:0]     ack_line,
    input logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] req_d;
    logic [NUM_LINES-1:0] ack_oh;

    // Independent record of the last request sample, cleared like the block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            req_d <= '0;
        else
            req_d <= req_in;
    end

    // One-hot view of the acknowledge for the hold property.
    always_comb begin
        ack_oh = '0;
        if (ack_valid)
            ack_oh[ack_line] = 1'b1;
    end

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((($past(req_in) ^ pending) & $past(mode_rdata)) == '0)); // R1

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> (($past(~mode_rdata & req_in & ~req_d) & ~pending) == '0)); // R2

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> (($past(pending & ~mode_rdata & ~ack_oh) & ~pending) == '0)); // R3

    AST_MODE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_rdata & ~MODE_WMASK) == '0)); // R4

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pending == '0)); // R8

    AST_CLR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !mode_we) |=> $stable(mode_rdata)); // R8

    AST_RESET_ZERO: assert property (@(posedge clk)
        (!rst_n) |=> (pending == '0 && mode_rdata == '0)); // R9

endmodule

bind irq_trig_capture irqcap_chk #(
    .NUM_LINES  (NUM_LINES),
    .MODE_WMASK (MODE_WMASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .req_in     (req_in),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .mode_rdata (mode_rdata),
    .ack_valid  (ack_valid),
    .ack_line   (ack_line),
    .pending    (pending)
);

// File: tb/irq_trig_capture_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic, all
// compared against a reference model stepped once per clock edge.
module irq_trig_capture_tb;

    localparam logic [7:0] MASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] req_in = '0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_line = '0;
    logic [7:0] pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_pend = '0;
    logic [7:0] m_prev = '0;
    logic [7:0] m_mode = '0;

    always #4 clk = ~clk;

    irq_trig_capture #(.NUM_LINES(8), .MODE_WMASK(MASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .req_in(req_in),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .ack_valid(ack_valid), .ack_line(ack_line), .pending(pending)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Next pending vector per the requirements, from the current model state.
    function automatic logic [7:0] model_pend(input logic [7:0] r,
                                              input logic av, input logic [2:0] al);
        logic [7:0] n;
        for (int i = 0; i < 8; i++) begin
            if (m_mode[i])
                n[i] = r[i];
            else
                n[i] = (r[i] & ~m_prev[i]) | (m_pend[i] & ~(av && al == 3'(i)));
        end
        return n;
    endfunction

    // One clock: drive at the falling edge, step the model, compare a cycle later.
    task automatic cyc(input logic [7:0] r, input logic we, input logic [7:0] wd,
                       input logic av, input logic [2:0] al, input logic c,
                       input logic rn, input string tag);
        logic [7:0] np;
        req_in = r; mode_we = we; mode_wdata = wd;
        ack_valid = av; ack_line = al; clr = c; rst_n = rn;
        if (!rn) begin
            m_pend = '0; m_prev = '0; m_mode = '0;
        end else begin
            np = c ? 8'h00 : model_pend(r, av, al);
            m_prev = c ? 8'h00 : r;
            m_pend = np;
            if (we) m_mode = wd & MASK;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "pending", pending, m_pend);
        chk("R4", "mode_rdata", mode_rdata, m_mode);
    endtask

    initial begin
        logic [7:0] rq;
        void'($urandom(32'h1234_abcd));
        @(negedge clk);
        cyc(8'h00, 0, 8'h00, 0, 3'd0, 0, 0, "R9");
        cyc(8'h00, 0, 8'h00, 0, 3'd0, 0, 0, "R9");
        chk("R9", "reset pending", pending, 8'h00);
        chk("R9", "reset mode", mode_rdata, 8'h00);
        // Edge mode set, hold on fall, acknowledge clears.
        cyc(8'h01, 0, 8'h00, 0, 3'd0, 0, 1, "R2");
        chk("R2", "rise sets", pending, 8'h01);
        cyc(8'h00, 0, 8'h00, 0, 3'd0, 0, 1, "R3");
        chk("R3", "fall holds", pending, 8'h01);
        cyc(8'h00, 0, 8'h00, 1, 3'd0, 0, 1, "R5");
        chk("R5", "ack clears", pending, 8'h00);
        // Masked mode write.
        cyc(8'h00, 1, 8'hFF, 0, 3'd0, 0, 1, "R4");
        chk("R4", "masked write", mode_rdata, 8'hF8);
        // Level line follows input; acknowledge has no effect.
        cyc(8'h08, 0, 8'h00, 0, 3'd0, 0, 1, "R1");
        chk("R1", "level high", pending, 8'h08);
        cyc(8'h08, 0, 8'h00, 1, 3'd3, 0, 1, "R6");
        chk("R6", "level ack ignored", pending, 8'h08);
        cyc(8'h00, 0, 8'h00, 0, 3'd0, 0, 1, "R1");
        chk("R1", "level low", pending, 8'h00);
        // Same-cycle acknowledge and new edge on edge line 1.
        cyc(8'h02, 0, 8'h00, 0, 3'd0, 0, 1, "R2");
        cyc(8'h00, 0, 8'h00, 0, 3'd0, 0, 1, "R3");
        cyc(8'h02, 0, 8'h00, 1, 3'd1, 0, 1, "R7");
        chk("R7", "edge wins", pending, 8'h02);
        // Acknowledge of another line leaves line 1 alone; held high no re-set.
        cyc(8'h02, 0, 8'h00, 1, 3'd0, 0, 1, "R5");
        chk("R5", "other ack", pending, 8'h02);
        cyc(8'h02, 0, 8'h00, 1, 3'd1, 0, 1, "R2");
        chk("R2", "held high no reset", pending, 8'h00);
        // Clear keeps the mode; held-high edge line re-pends after release.
        cyc(8'h03, 0, 8'h00, 0, 3'd0, 1, 1, "R8");
        chk("R8", "clear empties", pending, 8'h00);
        chk("R8", "clear keeps mode", mode_rdata, 8'hF8);
        cyc(8'h03, 0, 8'h00, 0, 3'd0, 0, 1, "R8");
        chk("R8", "re-edge after clear", pending, 8'h03);
        // Mode change timing on line 4 held high.
        cyc(8'h00, 1, 8'h00, 0, 3'd0, 0, 1, "R10");
        cyc(8'h10, 0, 8'h00, 0, 3'd0, 0, 1, "R10");
        cyc(8'h10, 0, 8'h00, 1, 3'd4, 0, 1, "R10");
        chk("R10", "edge acked", pending & 8'h10, 8'h00);
        cyc(8'h10, 1, 8'h10, 0, 3'd0, 0, 1, "R10");
        chk("R10", "write cycle still edge", pending & 8'h10, 8'h00);
        chk("R10", "readback next edge", mode_rdata, 8'h10);
        cyc(8'h10, 0, 8'h00, 0, 3'd0, 0, 1, "R10");
        chk("R10", "level from following edge", pending & 8'h10, 8'h10);
        // Reset clears the mode register as well.
        cyc(8'h10, 0, 8'h00, 0, 3'd0, 0, 0, "R9");
        chk("R9", "reset mode", mode_rdata, 8'h00);
        // Seeded random traffic.
        rq = '0;
        for (int k = 0; k < 4000; k++) begin
            rq = rq ^ 8'($urandom & $urandom & $urandom);
            cyc(rq, ($urandom % 16) == 0, 8'($urandom), ($urandom % 3) == 0,
                3'($urandom), ($urandom % 64) == 0, ($urandom % 500) != 0,
                "RAND R1 R2 R3 R5 R7");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule